// File: doc/BRIEF.md
# Dual-Handshake Transfer Sequencer

This block sits between a host-side parallel I/O port and a data acquisition unit whose handshakes do not match. The host port offers a ready line that reports FIFO status, a clear input, a direction input, a sync input, active-low read and write strobes, an external clear and a sync output. The acquisition unit uses a request/acknowledge pair, a two-bit destination code, a direction line and an overrun flag. The sequencer moves 16-bit words in either direction and converts one handshake into the other, with every interval counted in clock cycles set by parameters.

In the outbound direction (host to acquisition unit) each word costs two host reads. The first read carries only the destination code in its two top bits. The second read is the payload, which is then offered to the acquisition unit under request/acknowledge. In the inbound direction each acknowledged word is captured and presented to the host behind one write strobe. The block also halts inbound transfers on overrun, reports that a reset of the acquisition unit has completed, and abandons any handshake whose peer stops answering.

States: `ST_IDLE`, `ST_OB_RD1` (first read strobe low), `ST_OB_GAP` (strobe high, re-check), `ST_OB_RD2` (second read strobe low), `ST_OB_REQ` (request high, wait for acknowledge low), `ST_OB_DONE` (wait for acknowledge high), `ST_IB_REQ` (request high and write strobe low, wait for acknowledge high), `ST_IB_GAP` (fixed settle), `ST_IB_TAIL` (wait for acknowledge low). Transitions: IDLE→OB_RD1 when ready, clear high, not halted and direction high. IDLE→IB_REQ under the same conditions with direction low. OB_RD1→OB_GAP after `RD_LOW_CYC` cycles. OB_GAP→OB_RD2 once `RECHK_CYC` cycles have passed and ready and clear are high. OB_RD2→OB_REQ after `RD_LOW_CYC` cycles. OB_REQ→OB_DONE on acknowledge low. OB_DONE→IDLE on acknowledge high. IB_REQ→IB_GAP on acknowledge high. IB_GAP→IB_TAIL after `WR_GAP_CYC` cycles. IB_TAIL→IDLE on acknowledge low. Every waiting state goes →IDLE on timeout, and any state goes →IDLE while clear is low.

Top module: `hsbridge_ctrl`

## Requirements
- R1: `acq_dir` is always the inverse of `host_dir`. `host_dir` = 1 selects outbound (host to acquisition unit) and `host_dir` = 0 selects inbound.
- R2: An outbound word takes two host reads. At the end of the first read, bit 15 of `host_rdata` is latched onto `acq_dst[1]` and bit 14 onto `acq_dst[0]`. At the end of the second read, all of `host_rdata` is latched onto `acq_wdata`. The first word is never forwarded.
- R3: A read starts only from idle with `host_rdy` and `host_clr_n` both high. `host_rd_n` stays low for `RD_LOW_CYC` cycles and then high for at least `RECHK_CYC` cycles. The second read starts only when ready and clear are both high at or after that re-check point.
- R4: `acq_req` rises in the cycle the second read's low time ends, while `host_rd_n` stays low. The cycle after `acq_ack` is sampled low, `acq_req` is low and `host_rd_n` is high. The transfer ends when `acq_ack` is sampled high again.
- R5: An inbound transfer drives `acq_req` high and `host_wr_n` low in the same cycle. The cycle after `acq_ack` is sampled high, both are released and `host_wdata` holds the `acq_rdata` value sampled on that edge. The two strobes are never low together.
- R6: After an inbound write strobe rises, the block waits `WR_GAP_CYC` cycles and then for `acq_ack` low before it returns to idle and can start another transfer.
- R7: An `acq_ovf` sample while `host_dir` = 0 drives `host_xclr_n` low on the next cycle, and no new transfer starts while it is low. `acq_ovf` has no effect while `host_dir` = 1.
- R8: `host_sync_n` goes low the cycle after `acq_rst_done` is sampled high. It returns high the cycle after `host_clr_n` or `host_isync_n` is sampled low, and the release wins if both happen together.
- R9: Once low, `host_xclr_n` stays low until `acq_rst_done` is sampled high.
- R10: In `ST_OB_GAP`, `ST_OB_REQ`, `ST_OB_DONE`, `ST_IB_REQ` or `ST_IB_TAIL`, if the exit condition is still false after `TMO_CYC` cycles in that state, the block returns to idle and sets `err`. `err` stays set until `host_clr_n` is sampled low.
- R11: `host_clr_n` low returns the block to idle on the next cycle from any state, with `acq_req` low and both strobes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_dir | input | 1 | Host transfer direction, 1 = outbound |
| host_clr_n | input | 1 | Host clear, active low |
| host_rdy | input | 1 | Host FIFO status: data present (outbound) or room free (inbound) |
| host_isync_n | input | 1 | Host request to release the sync output, active low |
| host_rdata | input | 16 | Word read from the host |
| host_rd_n | output | 1 | Host read strobe, active low |
| host_wr_n | output | 1 | Host write strobe, active low; the rising edge commits |
| host_wdata | output | 16 | Word presented to the host |
| host_xclr_n | output | 1 | Halt indication to the host, active low |
| host_sync_n | output | 1 | Acquisition reset complete, active low |
| acq_req | output | 1 | Request to the acquisition unit |
| acq_ack | input | 1 | Acknowledge from the acquisition unit |
| acq_dst | output | 2 | Destination code for outbound words |
| acq_dir | output | 1 | Direction to the acquisition unit |
| acq_wdata | output | 16 | Outbound payload word |
| acq_rdata | input | 16 | Inbound word from the acquisition unit |
| acq_ovf | input | 1 | Acquisition FIFO overrun |
| acq_rst_done | input | 1 | Acquisition unit confirms a reset |
| err | output | 1 | Handshake timeout flag |

## Verification
The bench aims at the outbound re-check gap with ready withheld for several cycles. A design that ignored the re-check would start the second read early and shift the request by that many cycles. Destination codes 10, 01 and 11 catch swapped or misplaced code bits, and a forwarded first word would show up as the wrong payload. Slow inbound acknowledges make the tail wait matter, so a design that skipped it would begin the next write while the peer still held acknowledge. An overrun pulse, a reset confirmation arriving together with clear, a peer that never answers, and a clear in the middle of a read test the sticky halt, the release priority of sync, the timeout flag and the abort path.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OB_RD1,
        ST_OB_GAP,
        ST_OB_RD2,
        ST_OB_REQ,
        ST_OB_DONE,
        ST_IB_REQ,
        ST_IB_GAP,
        ST_IB_TAIL
    } hsb_state_e;

endpackage

// File: rtl/hsb_dwell.sv
// Counts cycles spent in the current state; restarts on every state change.
module hsb_dwell #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hsb_fsm.sv
module hsb_fsm
    import hsb_pkg::*;
#(
    parameter int RD_LOW_CYC = 8,
    parameter int RECHK_CYC  = 2,
    parameter int WR_GAP_CYC = 6,
    parameter int TMO_CYC    = 64,
    parameter int CW         = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dir,
    input  logic          clr_n,
    input  logic          rdy,
    input  logic          ack,
    input  logic          halt,
    input  logic [CW-1:0] cnt,
    output logic          restart,
    output logic          tmo,
    output logic          cap_dst,
    output logic          cap_word,
    output logic          cap_in,
    output logic          rd_n,
    output logic          wr_n,
    output logic          req
);
    localparam logic [CW-1:0] RD_END  = CW'(RD_LOW_CYC - 1);
    localparam logic [CW-1:0] RCK_END = CW'(RECHK_CYC - 1);
    localparam logic [CW-1:0] GAP_END = CW'(WR_GAP_CYC - 1);
    localparam logic [CW-1:0] TMO_END = CW'(TMO_CYC - 1);

    hsb_state_e st, nxt;
    logic       expired;

    assign expired = (cnt == TMO_END);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= nxt;
        end
    end

    // next state and timeout
    always_comb begin
        nxt = st;
        tmo = 1'b0;
        if (!clr_n) begin
            nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (rdy && !halt) nxt = dir ? ST_OB_RD1 : ST_IB_REQ;
                end
                ST_OB_RD1: begin
                    if (cnt == RD_END) nxt = ST_OB_GAP;
                end
                ST_OB_GAP: begin
                    if (cnt >= RCK_END && rdy) begin
                        nxt = ST_OB_RD2;
                    end else if (expired) begin
                        nxt = ST_IDLE;
                        tmo = 1'b1;
                    end
                end
                ST_OB_RD2: begin
                    if (cnt == RD_END) nxt = ST_OB_REQ;
                end
                ST_OB_REQ: begin
                    if (!ack) begin
                        nxt = ST_OB_DONE;
                    end else if (expired) begin
                        nxt = ST_IDLE;
                        tmo = 1'b1;
                    end
                end
                ST_OB_DONE: begin
                    if (ack) begin
                        nxt = ST_IDLE;
                    end else if (expired) begin
                        nxt = ST_IDLE;
                        tmo = 1'b1;
                    end
                end
                ST_IB_REQ: begin
                    if (ack) begin
                        nxt = ST_IB_GAP;
                    end else if (expired) begin
                        nxt = ST_IDLE;
                        tmo = 1'b1;
                    end
                end
                ST_IB_GAP: begin
                    if (cnt == GAP_END) nxt = ST_IB_TAIL;
                end
                ST_IB_TAIL: begin
                    if (!ack) begin
                        nxt = ST_IDLE;
                    end else if (expired) begin
                        nxt = ST_IDLE;
                        tmo = 1'b1;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    assign restart  = (nxt != st);
    assign cap_dst  = (st == ST_OB_RD1) && (nxt == ST_OB_GAP);
    assign cap_word = (st == ST_OB_RD2) && (nxt == ST_OB_REQ);
    assign cap_in   = (st == ST_IB_REQ) && (nxt == ST_IB_GAP);

    // Moore output decode
    always_comb begin
        rd_n = 1'b1;
        wr_n = 1'b1;
        req  = 1'b0;
        unique case (st)
            ST_OB_RD1, ST_OB_RD2: rd_n = 1'b0;
            ST_OB_REQ: begin
                rd_n = 1'b0;
                req  = 1'b1;
            end
            ST_IB_REQ: begin
                wr_n = 1'b0;
                req  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/hsb_status.sv
// Sync output, sticky overrun halt and timeout flag.
module hsb_status (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    input  logic isync_n,
    input  logic rst_done,
    input  logic ovf,
    input  logic dir,
    input  logic tmo,
    output logic sync_n,
    output logic halt,
    output logic err
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_n <= 1'b1;
            halt   <= 1'b0;
            err    <= 1'b0;
        end else begin
            if (!clr_n || !isync_n) begin
                sync_n <= 1'b1;
            end else if (rst_done) begin
                sync_n <= 1'b0;
            end

            if (rst_done) begin
                halt <= 1'b0;
            end else if (ovf && !dir) begin
                halt <= 1'b1;
            end

            if (!clr_n) begin
                err <= 1'b0;
            end else if (tmo) begin
                err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/hsb_capture.sv
// Holding registers for the destination code and both data directions.
module hsb_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_dst,
    input  logic         cap_word,
    input  logic         cap_in,
    input  logic [W-1:0] host_word,
    input  logic [W-1:0] acq_word,
    output logic [1:0]   dst,
    output logic [W-1:0] out_word,
    output logic [W-1:0] in_word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dst      <= '0;
            out_word <= '0;
            in_word  <= '0;
        end else begin
            if (cap_dst)  dst      <= host_word[W-1:W-2];
            if (cap_word) out_word <= host_word;
            if (cap_in)   in_word  <= acq_word;
        end
    end
endmodule

// File: rtl/hsbridge_ctrl.sv
module hsbridge_ctrl #(
    parameter int W          = 16,
    parameter int RD_LOW_CYC = 8,
    parameter int RECHK_CYC  = 2,
    parameter int WR_GAP_CYC = 6,
    parameter int TMO_CYC    = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         host_dir,
    input  logic         host_clr_n,
    input  logic         host_rdy,
    input  logic         host_isync_n,
    input  logic [W-1:0] host_rdata,
    output logic         host_rd_n,
    output logic         host_wr_n,
    output logic [W-1:0] host_wdata,
    output logic         host_xclr_n,
    output logic         host_sync_n,
    output logic         acq_req,
    input  logic         acq_ack,
    output logic [1:0]   acq_dst,
    output logic         acq_dir,
    output logic [W-1:0] acq_wdata,
    input  logic [W-1:0] acq_rdata,
    input  logic         acq_ovf,
    input  logic         acq_rst_done,
    output logic         err
);
    localparam int CW = $clog2(TMO_CYC + 1);

    logic [CW-1:0] cnt;
    logic          restart, tmo, halt;
    logic          cap_dst, cap_word, cap_in;

    assign acq_dir     = ~host_dir;
    assign host_xclr_n = ~halt;

    hsb_dwell #(.CW(CW)) u_dwell (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .cnt     (cnt)
    );

    hsb_fsm #(
        .RD_LOW_CYC (RD_LOW_CYC),
        .RECHK_CYC  (RECHK_CYC),
        .WR_GAP_CYC (WR_GAP_CYC),
        .TMO_CYC    (TMO_CYC),
        .CW         (CW)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .dir      (host_dir),
        .clr_n    (host_clr_n),
        .rdy      (host_rdy),
        .ack      (acq_ack),
        .halt     (halt),
        .cnt      (cnt),
        .restart  (restart),
        .tmo      (tmo),
        .cap_dst  (cap_dst),
        .cap_word (cap_word),
        .cap_in   (cap_in),
        .rd_n     (host_rd_n),
        .wr_n     (host_wr_n),
        .req      (acq_req)
    );

    hsb_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (host_clr_n),
        .isync_n  (host_isync_n),
        .rst_done (acq_rst_done),
        .ovf      (acq_ovf),
        .dir      (host_dir),
        .tmo      (tmo),
        .sync_n   (host_sync_n),
        .halt     (halt),
        .err      (err)
    );

    hsb_capture #(.W(W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_dst   (cap_dst),
        .cap_word  (cap_word),
        .cap_in    (cap_in),
        .host_word (host_rdata),
        .acq_word  (acq_rdata),
        .dst       (acq_dst),
        .out_word  (acq_wdata),
        .in_word   (host_wdata)
    );
endmodule

// File: rtl/hsb_chk.sv
module hsb_chk (
    input logic clk,
    input logic rst_n,
    input logic host_clr_n,
    input logic host_isync_n,
    input logic host_rd_n,
    input logic host_wr_n,
    input logic host_xclr_n,
    input logic host_sync_n,
    input logic acq_req,
    input logic acq_ack,
    input logic acq_rst_done,
    input logic err
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!host_rd_n && !host_wr_n)); // R5

    AST_OB_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_req && !host_rd_n && !acq_ack && host_clr_n) |=> (!acq_req && host_rd_n)); // R4

    AST_IB_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_req && !host_wr_n && acq_ack && host_clr_n) |=> (!acq_req && host_wr_n)); // R5

    AST_SYNC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_clr_n || !host_isync_n) |=> host_sync_n); // R8

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_xclr_n && !acq_rst_done) |=> !host_xclr_n); // R9

    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        !host_clr_n |=> !err); // R10

    AST_CLEAR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        !host_clr_n |=> (!acq_req && host_rd_n && host_wr_n)); // R11
endmodule

bind hsbridge_ctrl hsb_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_clr_n   (host_clr_n),
    .host_isync_n (host_isync_n),
    .host_rd_n    (host_rd_n),
    .host_wr_n    (host_wr_n),
    .host_xclr_n  (host_xclr_n),
    .host_sync_n  (host_sync_n),
    .acq_req      (acq_req),
    .acq_ack      (acq_ack),
    .acq_rst_done (acq_rst_done),
    .err          (err)
);

// File: tb/sim_hsbridge_ctrl.sv
module sim_hsbridge_ctrl;
    localparam int CLK_PERIOD = 20;
    localparam int RD_LOW = 8;
    localparam int RECHK  = 2;
    localparam int WRGAP  = 6;
    localparam int TMO    = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_dir = 1'b1, host_clr_n = 1'b1, host_rdy = 1'b0, host_isync_n = 1'b1;
    logic [15:0] host_rdata = '0;
    logic        host_rd_n, host_wr_n, host_xclr_n, host_sync_n;
    logic [15:0] host_wdata;
    logic        acq_req;
    logic        acq_ack = 1'b1;
    logic [1:0]  acq_dst;
    logic        acq_dir;
    logic [15:0] acq_wdata;
    logic [15:0] acq_rdata = '0;
    logic        acq_ovf = 1'b0, acq_rst_done = 1'b0;
    logic        err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hsbridge_ctrl #(.RD_LOW_CYC(RD_LOW), .RECHK_CYC(RECHK), .WR_GAP_CYC(WRGAP), .TMO_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .host_dir(host_dir), .host_clr_n(host_clr_n),
        .host_rdy(host_rdy), .host_isync_n(host_isync_n), .host_rdata(host_rdata),
        .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_wdata(host_wdata),
        .host_xclr_n(host_xclr_n), .host_sync_n(host_sync_n), .acq_req(acq_req),
        .acq_ack(acq_ack), .acq_dst(acq_dst), .acq_dir(acq_dir), .acq_wdata(acq_wdata),
        .acq_rdata(acq_rdata), .acq_ovf(acq_ovf), .acq_rst_done(acq_rst_done), .err(err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // phase: 0 idle, 1 read one, 2 re-check gap, 3 read two, 4 out request,
    //        5 out done, 6 in request, 7 in gap, 8 in tail
    int          ph = 0, n = 0;
    logic [1:0]  m_dst = '0;
    logic [15:0] m_aw = '0, m_hw = '0;
    logic        m_sync = 1'b1, m_halt = 1'b0, m_err = 1'b0;

    always @(posedge clk) begin
        int  nx;
        bit  to;
        if (!rst_n) begin
            ph = 0; n = 0; m_dst = '0; m_aw = '0; m_hw = '0;
            m_sync = 1'b1; m_halt = 1'b0; m_err = 1'b0;
        end else begin
            nx = ph; to = 0;
            if (!host_clr_n) nx = 0;
            else begin
                case (ph)
                    0: if (host_rdy && !m_halt) nx = host_dir ? 1 : 6;
                    1: if (n == RD_LOW-1) begin nx = 2; m_dst = host_rdata[15:14]; end
                    2: if (n >= RECHK-1 && host_rdy) nx = 3;
                       else if (n == TMO-1) begin nx = 0; to = 1; end
                    3: if (n == RD_LOW-1) begin nx = 4; m_aw = host_rdata; end
                    4: if (!acq_ack) nx = 5; else if (n == TMO-1) begin nx = 0; to = 1; end
                    5: if (acq_ack) nx = 0; else if (n == TMO-1) begin nx = 0; to = 1; end
                    6: if (acq_ack) begin nx = 7; m_hw = acq_rdata; end
                       else if (n == TMO-1) begin nx = 0; to = 1; end
                    7: if (n == WRGAP-1) nx = 8;
                    8: if (!acq_ack) nx = 0; else if (n == TMO-1) begin nx = 0; to = 1; end
                    default: nx = 0;
                endcase
            end
            if (!host_clr_n || !host_isync_n) m_sync = 1'b1;
            else if (acq_rst_done) m_sync = 1'b0;
            if (acq_rst_done) m_halt = 1'b0;
            else if (acq_ovf && !host_dir) m_halt = 1'b1;
            if (!host_clr_n) m_err = 1'b0;
            else if (to) m_err = 1'b1;
            n = (nx != ph) ? 0 : n + 1;
            ph = nx;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 host_rd_n", host_rd_n, !(ph == 1 || ph == 3 || ph == 4));
            check("R4 acq_req", acq_req, (ph == 4 || ph == 6));
            check("R6 host_wr_n", host_wr_n, (ph != 6));
            check("R2 acq_dst", acq_dst, m_dst);
            check("R2 acq_wdata", acq_wdata, m_aw);
            check("R5 host_wdata", host_wdata, m_hw);
            check("R8 host_sync_n", host_sync_n, m_sync);
            check("R7 host_xclr_n", host_xclr_n, !m_halt);
            check("R10 err", err, m_err);
            check("R1 acq_dir", acq_dir, !host_dir);
        end
    end

    // ---------------- acquisition unit responder ----------------
    int          rsp_dly = 3;
    bit          mute = 0;
    int          rc = 0;
    logic [15:0] last_in = '0;
    logic [15:0] seq = 16'hA500;

    always @(negedge clk) begin
        if (host_dir) begin
            if (acq_req && acq_ack) begin
                rc++;
                if (rc >= rsp_dly && !mute) begin acq_ack = 1'b0; rc = 0; end
            end else if (!acq_req && !acq_ack) begin
                rc++;
                if (rc >= rsp_dly && !mute) begin acq_ack = 1'b1; rc = 0; end
            end else rc = 0;
        end else begin
            if (acq_req && !acq_ack) begin
                rc++;
                if (rc >= rsp_dly && !mute) begin
                    seq = seq + 16'h0111;
                    acq_rdata = seq; last_in = seq;
                    acq_ack = 1'b1; rc = 0;
                end
            end else if (!acq_req && acq_ack) begin
                rc++;
                if (rc >= rsp_dly && !mute) begin acq_ack = 1'b0; rc = 0; end
            end else rc = 0;
        end
    end

    task automatic cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic ob_xfer(input logic [15:0] w1, input logic [15:0] w2, input int hold);
        host_rdata = w1;
        host_rdy = 1'b1;
        @(negedge clk); while (host_rd_n) @(negedge clk);
        while (!host_rd_n) @(negedge clk);
        host_rdata = w2;
        if (hold > 0) begin host_rdy = 1'b0; cyc(hold); host_rdy = 1'b1; end
        while (host_rd_n) @(negedge clk);
        host_rdy = 1'b0;
        while (!acq_req) @(negedge clk);
        while (acq_req) @(negedge clk);
        while (!acq_ack) @(negedge clk);
        cyc(3);
        check("R2 destination code", acq_dst, w1[15:14]);
        check("R2 payload word", acq_wdata, w2);
    endtask

    initial begin
        int rises;
        bit saw;
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        // reset state
        check("R11 reset rd_n", host_rd_n, 1);
        check("R11 reset wr_n", host_wr_n, 1);
        check("R4 reset req", acq_req, 0);
        check("R8 reset sync", host_sync_n, 1);
        check("R7 reset xclr", host_xclr_n, 1);
        check("R10 reset err", err, 0);
        check("R1 dir outbound", acq_dir, 0);

        // outbound: codes 10, 01, 11; re-check hold varies
        ob_xfer(16'h8001, 16'h1234, 0);
        ob_xfer(16'h4FFF, 16'hBEEF, 5);
        rsp_dly = 7;
        ob_xfer(16'hC000, 16'h0F0F, 1);
        ob_xfer(16'h3FFF, 16'h5A5A, 0);  // code 00 even with low bits set

        // inbound
        host_dir = 1'b0;
        cyc(12);
        check("R1 dir inbound", acq_dir, 1);
        rsp_dly = 2;
        host_rdy = 1'b1;
        rises = 0;
        while (rises < 2) begin @(negedge clk); if (!host_wr_n) begin while (!host_wr_n) @(negedge clk); rises++; end end
        rsp_dly = 10;   // slow release: tail wait R6
        while (rises < 4) begin @(negedge clk); if (!host_wr_n) begin while (!host_wr_n) @(negedge clk); rises++; end end
        host_rdy = 1'b0;
        cyc(20);
        check("R5 inbound word", host_wdata, last_in);
        check("R6 back to idle", acq_req, 0);

        // overrun while inbound
        rsp_dly = 2;
        acq_ovf = 1'b1; cyc(1); acq_ovf = 1'b0; cyc(1);
        check("R7 halt on overrun", host_xclr_n, 0);
        host_rdy = 1'b1;
        saw = 0;
        repeat (30) begin @(negedge clk); if (acq_req || !host_wr_n) saw = 1; end
        check("R7 no transfer while halted", saw, 0);
        check("R9 halt stays low", host_xclr_n, 0);
        host_rdy = 1'b0;
        acq_rst_done = 1'b1; cyc(1); acq_rst_done = 1'b0; cyc(1);
        check("R9 halt released by reset", host_xclr_n, 1);
        check("R8 sync low on reset done", host_sync_n, 0);
        host_isync_n = 1'b0; cyc(1); host_isync_n = 1'b1; cyc(1);
        check("R8 sync released by host", host_sync_n, 1);
        acq_rst_done = 1'b1; cyc(1); acq_rst_done = 1'b0; cyc(1);
        check("R8 sync low again", host_sync_n, 0);
        acq_rst_done = 1'b1; host_clr_n = 1'b0; cyc(1);
        acq_rst_done = 1'b0; host_clr_n = 1'b1; cyc(1);
        check("R8 release wins", host_sync_n, 1);

        // overrun ignored outbound
        host_dir = 1'b1;
        cyc(12);
        acq_ovf = 1'b1; cyc(1); acq_ovf = 1'b0; cyc(2);
        check("R7 overrun ignored outbound", host_xclr_n, 1);

        // timeout
        mute = 1;
        host_rdata = 16'h8000; host_rdy = 1'b1;
        @(negedge clk); while (!acq_req) @(negedge clk);
        host_rdy = 1'b0;
        cyc(TMO + 4);
        check("R10 timeout flag", err, 1);
        check("R10 idle after timeout", acq_req, 0);
        mute = 0;
        cyc(3);
        host_clr_n = 1'b0; cyc(1); host_clr_n = 1'b1; cyc(1);
        check("R10 flag cleared", err, 0);

        // abort by clear mid read
        host_rdy = 1'b1;
        @(negedge clk); while (host_rd_n) @(negedge clk);
        cyc(2);
        host_clr_n = 1'b0; host_rdy = 1'b0; cyc(1);
        check("R11 abort rd_n", host_rd_n, 1);
        check("R11 abort req", acq_req, 0);
        host_clr_n = 1'b1;
        cyc(6);
        check("R11 stays idle", host_rd_n, 1);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule